// File: doc/BRIEF.md
# Stepper Bridge Protection and Power-State Supervisor

This block sits between the pins and sensors of a two-winding stepper driver and the logic that drives the bridges and runs the step indexer. It takes the active-low bridge enable, the active-low doze (low-power) request and the active-low indexer hold inputs. It also takes raw flags from the overcurrent, over-temperature and supply-undervoltage detectors. From these it produces three registered outputs: a bridge output-enable, a one-cycle pulse that returns the indexer to its home position, and a qualifier that says when step commands may be accepted.

Every input passes through a reset-safe synchroniser. The protection behaviour works as follows:

- **Overcurrent** is filtered by a deglitch window. A qualified event latches the bridges off until a retry interval has elapsed, or until the enable input is taken inactive and then active again.
- **Over-temperature and undervoltage** force the bridges off for as long as they last, and they freeze the overcurrent retry interval meanwhile.
- **Home pulse:** the qualified overcurrent event, the onset of over-temperature, the onset of undervoltage and the entry into indexer hold each produce one home pulse.
- **Wake delay:** after the doze request is released, step acceptance waits for a wake interval.

All intervals are given in nanoseconds and turned into cycle counts from the clock-frequency parameter.

Top module: `mdrv_guard`

## Requirements
- R1: While `rst` is high, and after it is released with quiet inputs, `bridge_oe`, `step_ok` and `home_clr` are 0, and no home pulse is produced before any event.
- R2: Each input passes through SYNC_STAGES (default 2) flip-flops, and the outputs are registered. A change applied before clock edge 1 is visible on the outputs after edge 3 and not after edge 2.
- R3: `bridge_en_n` = 1 forces `bridge_oe` = 0 while `step_ok` keeps its value.
- R4: `doze_n` = 0 forces `bridge_oe` = 0 and `step_ok` = 0. While dozing, the hold, enable and overcurrent inputs have no effect and cause no home pulse. After `doze_n` returns to 1, `bridge_oe` recovers with the normal latency, but `step_ok` rises only after WAKE_CYC cycles: after edge WAKE_CYC+3, counted from the release.
- R5: `idx_hold_n` = 0 while awake forces `bridge_oe` = 0 and `step_ok` = 0, and produces exactly one home pulse on entry.
- R6: An overcurrent flag counts only after DEG_CYC consecutive synchronised high samples. A pulse of DEG_CYC-1 cycles has no effect.
- R7: A qualified overcurrent drops `bridge_oe` after edge DEG_CYC+2 and produces one home pulse. It holds `bridge_oe` at 0 for RETRY_CYC cycles, with `bridge_oe` returning after edge RETRY_CYC+1 counted from the trip. `step_ok` is unaffected.
- R8: During the overcurrent lockout, a rise of `bridge_en_n` followed by a fall ends the lockout early.
- R9: `ot_raw` = 1 forces `bridge_oe` = 0 and `step_ok` = 0 and produces one home pulse at onset. Operation resumes by itself when the flag clears.
- R10: Either undervoltage flag forces `bridge_oe` = 0 and `step_ok` = 0, with one home pulse at the onset of the combined condition. Operation resumes only when both flags are 0.
- R11: While over-temperature or undervoltage is present, the overcurrent retry interval does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| bridge_en_n | input | 1 | Active-low bridge enable; high puts bridges in high impedance |
| doze_n | input | 1 | Active-low low-power request |
| idx_hold_n | input | 1 | Active-low indexer hold; keeps indexer at home and blocks steps |
| oc_raw | input | 1 | Raw overcurrent detector flag |
| ot_raw | input | 1 | Raw over-temperature flag |
| uv_mot_raw | input | 1 | Motor-supply undervoltage flag |
| uv_log_raw | input | 1 | Logic-supply undervoltage flag |
| bridge_oe | output | 1 | Output-enable for both bridges |
| home_clr | output | 1 | One-cycle pulse returning the indexer to home |
| step_ok | output | 1 | Step commands may be accepted |

## Verification
The bench aims at the edges of the deglitch window: a DEG_CYC-1 pulse and a DEG_CYC pulse are applied back to back, so a counter that is off by one either trips on a glitch or needs an extra cycle. The release of the overcurrent lockout is timed to the exact cycle, and the enable-toggle path is checked to recover well before the retry interval ends. A design whose retry timer kept running under over-temperature would re-enable the bridges before the check that expects them still off. Hold, enable and overcurrent activity during doze must leave the home-pulse count unchanged, and step acceptance is sampled one cycle before and one cycle after the wake boundary.

// File: rtl/mdrv_guard_pkg.sv
package mdrv_guard_pkg;

    typedef enum logic [1:0] {
        OC_IDLE  = 2'd0,
        OC_LOCK  = 2'd1,
        OC_ARMED = 2'd2
    } oc_state_e;

    typedef struct packed {
        logic uv_log;
        logic uv_mot;
        logic ot;
        logic oc;
        logic hold_n;
        logic doze_n;
        logic en_n;
    } pins_t;

    localparam int PIN_W = $bits(pins_t);

    // Values the synchroniser holds during reset: asleep, disabled, supplies low.
    localparam pins_t PINS_SAFE = '{uv_log: 1'b1, uv_mot: 1'b1, ot: 1'b0, oc: 1'b0,
                                    hold_n: 1'b0, doze_n: 1'b0, en_n: 1'b1};

    typedef struct packed {
        logic asleep;
        logic uv;
        logic therm;
        logic hold;
        logic dis;
        logic oc_off;
        logic woke;
    } cond_t;

    function automatic int ns_to_cyc(longint hz, longint ns);
        longint c;
        c = ((hz / 64'sd1000) * ns) / 64'sd1000000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic logic drive_ok(cond_t c);
        return !(c.asleep | c.uv | c.therm | c.hold | c.dis | c.oc_off);
    endfunction

    function automatic logic step_gate(cond_t c);
        return c.woke & !(c.asleep | c.uv | c.therm | c.hold);
    endfunction

endpackage

// File: rtl/mdrv_sync.sv
module mdrv_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= RST_VAL;
                else     q <= din;
            end
            assign dout = q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] pipe;
            always_ff @(posedge clk) begin
                if (rst) pipe <= {STAGES{RST_VAL}};
                else     pipe <= {pipe[STAGES-2:0], din};
            end
            assign dout = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mdrv_oc_guard.sv
module mdrv_oc_guard
    import mdrv_guard_pkg::*;
#(
    parameter int DEG_CYC   = 75,
    parameter int RETRY_CYC = 40000
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_s,
    input  logic en_n_s,
    input  logic asleep,
    input  logic suppress,
    input  logic hold,
    output logic trip,
    output logic off
);
    localparam int DW = $clog2(DEG_CYC + 1);
    localparam int RW = $clog2(RETRY_CYC + 1);
    localparam logic [DW-1:0] DEG_LAST = DW'(DEG_CYC - 1);
    localparam logic [RW-1:0] RTY_LAST = RW'(RETRY_CYC - 1);

    oc_state_e      st;
    logic [DW-1:0]  deg_cnt;
    logic [RW-1:0]  rty_cnt;
    logic           rty_done;

    assign trip     = (st == OC_IDLE) && oc_s && !suppress && (deg_cnt == DEG_LAST);
    assign rty_done = (rty_cnt == RTY_LAST) && !hold;
    assign off      = (st != OC_IDLE) || trip;

    // Deglitch: consecutive high samples while idle and awake.
    always_ff @(posedge clk) begin
        if (rst || st != OC_IDLE || !oc_s || suppress) deg_cnt <= '0;
        else if (deg_cnt != DEG_LAST)                   deg_cnt <= deg_cnt + 1'b1;
    end

    // Retry interval: frozen while a higher-priority condition holds.
    always_ff @(posedge clk) begin
        if (rst || st == OC_IDLE)                      rty_cnt <= '0;
        else if (!hold && rty_cnt != RTY_LAST)         rty_cnt <= rty_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= OC_IDLE;
        end else begin
            unique case (st)
                OC_IDLE:  if (trip) st <= OC_LOCK;
                OC_LOCK: begin
                    if (rty_done)                st <= OC_IDLE;
                    else if (!asleep && en_n_s)  st <= OC_ARMED;
                end
                OC_ARMED: if (rty_done || (!asleep && !en_n_s)) st <= OC_IDLE;
                default:  st <= OC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdrv_wake.sv
module mdrv_wake #(
    parameter int WAKE_CYC = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic awake,
    output logic done
);
    localparam int CW = $clog2(WAKE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYC);

    logic [CW-1:0] cnt;

    assign done = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !awake) cnt <= '0;
        else if (!done)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mdrv_onset.sv
module mdrv_onset #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic prev;
        always_ff @(posedge clk) begin
            if (rst) prev <= RST_VAL[i];
            else     prev <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev;
    end
endmodule

// File: rtl/mdrv_guard.sv
module mdrv_guard
    import mdrv_guard_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned DEGLITCH_NS = 1_500,
    parameter int unsigned RETRY_NS    = 800_000,
    parameter int unsigned WAKE_NS     = 1_000_000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bridge_en_n,
    input  logic doze_n,
    input  logic idx_hold_n,
    input  logic oc_raw,
    input  logic ot_raw,
    input  logic uv_mot_raw,
    input  logic uv_log_raw,
    output logic bridge_oe,
    output logic home_clr,
    output logic step_ok
);
    localparam int DEG_CYC   = ns_to_cyc(longint'(CLK_HZ), longint'(DEGLITCH_NS));
    localparam int RETRY_CYC = ns_to_cyc(longint'(CLK_HZ), longint'(RETRY_NS));
    localparam int WAKE_CYC  = ns_to_cyc(longint'(CLK_HZ), longint'(WAKE_NS));
    localparam int EV_W      = 3;

    pins_t             raw_pins;
    pins_t             pins;
    logic [PIN_W-1:0]  pins_vec;
    cond_t             cond;
    logic              oc_trip, oc_off, woke;
    logic [EV_W-1:0]   ev_lvl, ev_rise;

    assign raw_pins = '{uv_log: uv_log_raw, uv_mot: uv_mot_raw, ot: ot_raw, oc: oc_raw,
                        hold_n: idx_hold_n, doze_n: doze_n, en_n: bridge_en_n};

    mdrv_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_W'(PINS_SAFE))
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (PIN_W'(raw_pins)),
        .dout(pins_vec)
    );

    assign pins = pins_t'(pins_vec);

    always_comb begin
        cond.asleep = !pins.doze_n;
        cond.uv     = pins.uv_mot | pins.uv_log;
        cond.therm  = pins.ot & !cond.asleep;
        cond.hold   = !pins.hold_n & !cond.asleep;
        cond.dis    = pins.en_n;
        cond.oc_off = oc_off;
        cond.woke   = woke;
    end

    mdrv_oc_guard #(
        .DEG_CYC  (DEG_CYC),
        .RETRY_CYC(RETRY_CYC)
    ) u_oc (
        .clk     (clk),
        .rst     (rst),
        .oc_s    (pins.oc),
        .en_n_s  (pins.en_n),
        .asleep  (cond.asleep),
        .suppress(cond.asleep | cond.uv),
        .hold    (cond.asleep | cond.uv | cond.therm),
        .trip    (oc_trip),
        .off     (oc_off)
    );

    mdrv_wake #(
        .WAKE_CYC(WAKE_CYC)
    ) u_wake (
        .clk  (clk),
        .rst  (rst),
        .awake(!cond.asleep),
        .done (woke)
    );

    assign ev_lvl = {cond.uv, cond.therm, cond.hold};

    mdrv_onset #(
        .W      (EV_W),
        .RST_VAL(3'b100)
    ) u_onset (
        .clk (clk),
        .rst (rst),
        .lvl (ev_lvl),
        .rise(ev_rise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bridge_oe <= 1'b0;
            step_ok   <= 1'b0;
            home_clr  <= 1'b0;
        end else begin
            bridge_oe <= drive_ok(cond);
            step_ok   <= step_gate(cond);
            home_clr  <= oc_trip | (|ev_rise);
        end
    end
endmodule

// File: rtl/mdrv_guard_chk.sv
module mdrv_guard_chk #(
    parameter int WAKE_CYC = 50000
) (
    input logic clk,
    input logic rst,
    input logic bridge_en_n,
    input logic doze_n,
    input logic idx_hold_n,
    input logic ot_raw,
    input logic uv_mot_raw,
    input logic uv_log_raw,
    input logic bridge_oe,
    input logic step_ok
);
    int since_lo;

    always_ff @(posedge clk) begin
        if (rst || !doze_n)          since_lo <= 0;
        else if (since_lo < WAKE_CYC) since_lo <= since_lo + 1;
    end

    AST_EN_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        bridge_en_n && $past(bridge_en_n) && $past(bridge_en_n, 2) |=> !bridge_oe); // R3

    AST_DOZE_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        !doze_n && !$past(doze_n) && !$past(doze_n, 2) |=> !bridge_oe && !step_ok); // R4

    AST_WAKE_WAIT: assert property (@(posedge clk) disable iff (rst)
        step_ok |-> (since_lo >= WAKE_CYC) || (since_lo < 3)); // R4

    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        !idx_hold_n && !$past(idx_hold_n) && !$past(idx_hold_n, 2) |=> !bridge_oe && !step_ok); // R5

    AST_THERM_OFF: assert property (@(posedge clk) disable iff (rst)
        ot_raw && $past(ot_raw) && $past(ot_raw, 2) |=> !bridge_oe); // R9

    AST_UV_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(uv_mot_raw || uv_log_raw, 2) |=> !bridge_oe && !step_ok); // R10
endmodule

bind mdrv_guard mdrv_guard_chk #(.WAKE_CYC(WAKE_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bridge_en_n(bridge_en_n),
    .doze_n     (doze_n),
    .idx_hold_n (idx_hold_n),
    .ot_raw     (ot_raw),
    .uv_mot_raw (uv_mot_raw),
    .uv_log_raw (uv_log_raw),
    .bridge_oe  (bridge_oe),
    .step_ok    (step_ok)
);

// File: tb/mdrv_guard_test.sv
`timescale 1ns/1ps
module mdrv_guard_test;
    // 50 MHz: one cycle per 20 ns
    localparam int DEG   = 1500 / 20;
    localparam int RETRY = 8000 / 20;
    localparam int WAKE  = 10000 / 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bridge_en_n = 1'b0, doze_n = 1'b1, idx_hold_n = 1'b1;
    logic oc_raw = 1'b0, ot_raw = 1'b0, uv_mot_raw = 1'b0, uv_log_raw = 1'b0;
    logic bridge_oe, home_clr, step_ok;

    int nchk = 0, nfail = 0, home_cnt = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) if (home_clr) home_cnt <= home_cnt + 1;

    mdrv_guard #(
        .CLK_HZ(50_000_000), .DEGLITCH_NS(1500), .RETRY_NS(8000),
        .WAKE_NS(10000), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst(rst), .bridge_en_n(bridge_en_n), .doze_n(doze_n),
        .idx_hold_n(idx_hold_n), .oc_raw(oc_raw), .ot_raw(ot_raw),
        .uv_mot_raw(uv_mot_raw), .uv_log_raw(uv_log_raw),
        .bridge_oe(bridge_oe), .home_clr(home_clr), .step_ok(step_ok)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_startup();
        tick(5);
        chk("R1 oe in reset", bridge_oe, 0);
        chk("R1 step in reset", step_ok, 0);
        chk("R1 home in reset", home_clr, 0);
        rst = 1'b0;
        tick(2);
        chk("R2 oe before edge 3", bridge_oe, 0);
        tick(1);
        chk("R2 oe after edge 3", bridge_oe, 1);
        tick(WAKE - 1);
        chk("R4 step before wake", step_ok, 0);
        tick(1);
        chk("R4 step after wake", step_ok, 1);
        chk("R1 no spurious home", home_cnt, 0);
    endtask

    task automatic t_enable();
        bridge_en_n = 1'b1;
        tick(3);
        chk("R3 oe off when disabled", bridge_oe, 0);
        chk("R3 step kept when disabled", step_ok, 1);
        bridge_en_n = 1'b0;
        tick(2);
        chk("R2 enable latency edge 2", bridge_oe, 0);
        tick(1);
        chk("R2 enable latency edge 3", bridge_oe, 1);
    endtask

    task automatic t_doze();
        int h0 = home_cnt;
        doze_n = 1'b0;
        tick(3);
        chk("R4 oe off in doze", bridge_oe, 0);
        chk("R4 step off in doze", step_ok, 0);
        idx_hold_n = 1'b0; bridge_en_n = 1'b1; oc_raw = 1'b1;
        tick(DEG + 40);
        idx_hold_n = 1'b1; bridge_en_n = 1'b0; oc_raw = 1'b0;
        tick(5);
        chk("R4 inputs ignored in doze", home_cnt, h0);
        doze_n = 1'b1;
        tick(3);
        chk("R4 oe back after doze", bridge_oe, 1);
        tick(WAKE - 1);
        chk("R4 step waits for wake", step_ok, 0);
        tick(1);
        chk("R4 step after wake interval", step_ok, 1);
    endtask

    task automatic t_hold();
        int h0 = home_cnt;
        idx_hold_n = 1'b0;
        tick(3);
        chk("R5 oe off in hold", bridge_oe, 0);
        chk("R5 step blocked in hold", step_ok, 0);
        tick(22);
        chk("R5 single home pulse", home_cnt, h0 + 1);
        idx_hold_n = 1'b1;
        tick(3);
        chk("R5 oe back", bridge_oe, 1);
        chk("R5 step back", step_ok, 1);
    endtask

    task automatic t_deglitch_retry();
        int h0 = home_cnt;
        oc_raw = 1'b1;
        tick(DEG - 1);
        oc_raw = 1'b0;
        tick(10);
        chk("R6 short pulse keeps oe", bridge_oe, 1);
        chk("R6 short pulse no home", home_cnt, h0);
        oc_raw = 1'b1;
        tick(DEG);
        oc_raw = 1'b0;
        tick(1);
        chk("R6 oe before qualification", bridge_oe, 1);
        tick(1);
        chk("R7 oe off after trip", bridge_oe, 0);
        chk("R7 step unaffected", step_ok, 1);
        tick(2);
        chk("R7 home pulse on trip", home_cnt, h0 + 1);
        tick(RETRY - 2);
        chk("R7 still locked at end", bridge_oe, 0);
        tick(1);
        chk("R7 released after retry", bridge_oe, 1);
    endtask

    task automatic t_toggle();
        oc_raw = 1'b1;
        tick(DEG + 5);
        oc_raw = 1'b0;
        tick(3);
        chk("R8 locked before toggle", bridge_oe, 0);
        bridge_en_n = 1'b1;
        tick(10);
        bridge_en_n = 1'b0;
        tick(6);
        chk("R8 toggle ends lockout", bridge_oe, 1);
    endtask

    task automatic t_thermal();
        int h0 = home_cnt;
        ot_raw = 1'b1;
        tick(3);
        chk("R9 oe off hot", bridge_oe, 0);
        chk("R9 step off hot", step_ok, 0);
        tick(2);
        chk("R9 home on onset", home_cnt, h0 + 1);
        ot_raw = 1'b0;
        tick(3);
        chk("R9 oe resumes", bridge_oe, 1);
        chk("R9 step resumes", step_ok, 1);
    endtask

    task automatic t_uv();
        int h0 = home_cnt;
        uv_mot_raw = 1'b1;
        tick(3);
        chk("R10 oe off on uv", bridge_oe, 0);
        chk("R10 step off on uv", step_ok, 0);
        uv_log_raw = 1'b1;
        tick(5);
        uv_mot_raw = 1'b0;
        tick(10);
        chk("R10 one supply still low", bridge_oe, 0);
        chk("R10 step still off", step_ok, 0);
        chk("R10 single home pulse", home_cnt, h0 + 1);
        uv_log_raw = 1'b0;
        tick(3);
        chk("R10 oe resumes", bridge_oe, 1);
        chk("R10 step resumes", step_ok, 1);
    endtask

    task automatic t_priority();
        oc_raw = 1'b1;
        tick(DEG + 5);
        oc_raw = 1'b0;
        tick(100);
        ot_raw = 1'b1;
        tick(RETRY + 200);
        ot_raw = 1'b0;
        tick(20);
        chk("R11 retry paused while hot", bridge_oe, 0);
        tick(RETRY);
        chk("R11 retry completes later", bridge_oe, 1);
    endtask

    initial begin
        t_startup();
        t_enable();
        t_doze();
        t_hold();
        t_deglitch_retry();
        t_toggle();
        t_thermal();
        t_uv();
        t_priority();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule